// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block unlocks a door once a stored three-value code has been keyed in one value at a time. With each value, the user presents it on a multi-bit bus and pulses a "new" strobe. The strobe and the value bus arrive from outside the clock domain. Both pass through a synchroniser chain of the same depth, so they stay aligned. A rising-edge detector then turns each press into exactly one entry, however long the button is held.

A state machine tracks how far into the code the user has progressed. One right value takes it from START to GOT1. The next takes it to GOT2, and the third takes it to OPEN. A wrong value at any step sends it to ERROR. OPEN and ERROR are both sticky, and only the synchronous, active-high reset returns the machine to START. The door output comes from a register in the datapath. It goes high on the same clock edge at which the controller enters OPEN.

The code words and the value width are parameters. By default the value is 4 bits wide and the code is 3, then 9, then 5.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a rising clock edge, the lock returns to its start step and `doorOpen` is low after that edge.
- R2: Entering the three code values in order, each with its own press of `newIn`, raises `doorOpen`. The default code, with a 4-bit value, is 3, then 9, then 5.
- R3: `doorOpen` is registered. After the press carrying the third correct value starts, the door stays low once two clock edges have passed and goes high at the third edge. It is high only while the lock is in its open step.
- R4: A value that does not match the code word expected at the current step sends the lock to an error step, and `doorOpen` stays low. This holds at any of the three steps.
- R5: A press of `newIn` held high for many cycles counts as one entry.
- R6: Once the door is open, further presses, whether with right or wrong values, have no effect, and `doorOpen` stays high until reset.
- R7: The error step is left only through reset. A correct full code entered in error leaves the door closed. After reset, the same code opens it.
- R8: Reset takes priority over a press that is detected in the same cycle. That press advances nothing.
- R9: After only one or two correct values, `doorOpen` remains low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valueIn | input | VAL_W | Value being entered, held stable while `newIn` is high |
| newIn | input | 1 | Press strobe marking one entered value, asynchronous |
| doorOpen | output | 1 | High while the door is unlocked |

## Verification
Some rules are checked by assertions on every cycle. The door register must agree with the open step at all times. The open and error steps must never be left without reset, and reset must always return the machine to its start. A mismatching press must lead to error, the open step may be reached only from the second-correct step, and the edge detector may never produce two entry pulses in a row. Other behaviour shows only in the bench scenarios, which run end to end through the synchronisers. These cover the exact edge at which the door rises, a long press counted once, a wrong value at each of the three steps, and a press that is swallowed by a reset asserted over it.

// File: rtl/lock_pkg.sv
package lock_pkg;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_GOT1  = 3'd1,
    ST_GOT2  = 3'd2,
    ST_OPEN  = 3'd3,
    ST_ERROR = 3'd4
  } lockState_t;

  localparam int unsigned CODE_LEN = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic [1:0] stepSel;   // which code word to compare against
    logic       setOpen;   // unlock on this edge
    logic       clearOpen; // lock on this edge
  } ctlStrobe_t;

endpackage

// File: rtl/lock_strobe_sync.sv
module lock_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic newIn,
  output logic pressPulse
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncChain[g] <= 1'b0;
          else     syncChain[g] <= newIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) syncChain[g] <= 1'b0;
          else     syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prevLevel <= 1'b0;
    else     prevLevel <= syncChain[LAST];
  end

  assign pressPulse = syncChain[LAST] & ~prevLevel;

  // R5: a held press yields a single-cycle entry pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pressPulse |=> !pressPulse);

endmodule

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CODE0       = 3,
  parameter int unsigned CODE1       = 9,
  parameter int unsigned CODE2       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] valueIn,
  input  ctlStrobe_t       ctl,
  output logic             valueMatch,
  output logic             doorReg
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [VAL_W-1:0] valueChain [SYNC_STAGES];
  logic [VAL_W-1:0] codeTab    [CODE_LEN];

  // Value synchroniser, same depth as the strobe chain so they align
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_vstage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) valueChain[g] <= '0;
          else     valueChain[g] <= valueIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) valueChain[g] <= '0;
          else     valueChain[g] <= valueChain[g-1];
        end
      end
    end
  endgenerate

  assign codeTab[0] = VAL_W'(CODE0);
  assign codeTab[1] = VAL_W'(CODE1);
  assign codeTab[2] = VAL_W'(CODE2);

  always_comb begin
    valueMatch = 1'b0;
    for (int i = 0; i < CODE_LEN; i++) begin
      if (ctl.stepSel == 2'(i)) valueMatch = (valueChain[LAST] == codeTab[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.clearOpen)    doorReg <= 1'b0;
    else if (ctl.setOpen) doorReg <= 1'b1;
  end

  // R1: reset always leaves the door locked
  a_r1_door_cleared: assert property (@(posedge clk)
    ctl.clearOpen |=> !doorReg);

endmodule

// File: rtl/lock_control.sv
module lock_control
  import lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pressPulse,
  input  logic       valueMatch,
  output ctlStrobe_t ctl,
  output lockState_t stateOut
);

  lockState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (pressPulse) begin
      unique case (state)
        ST_START: stateNext = valueMatch ? ST_GOT1 : ST_ERROR;
        ST_GOT1:  stateNext = valueMatch ? ST_GOT2 : ST_ERROR;
        ST_GOT2:  stateNext = valueMatch ? ST_OPEN : ST_ERROR;
        default:  stateNext = state; // OPEN and ERROR ignore presses
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_START;
    else     state <= stateNext;
  end

  always_comb begin
    unique case (state)
      ST_GOT1: ctl.stepSel = 2'd1;
      ST_GOT2: ctl.stepSel = 2'd2;
      default: ctl.stepSel = 2'd0;
    endcase
    ctl.clearOpen = rst;
    ctl.setOpen   = !rst && (state == ST_GOT2) && (stateNext == ST_OPEN);
  end

  assign stateOut = state;

  // R1: reset returns to the start step
  a_r1_reset_start: assert property (@(posedge clk)
    rst |=> (state == ST_START));

  // R6: open is left only through reset
  a_r6_open_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPEN) |=> (state == ST_OPEN));

  // R7: error is left only through reset
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERROR) |=> (state == ST_ERROR));

  // R4: a mismatching press during entry leads to error
  a_r4_wrong_to_error: assert property (@(posedge clk) disable iff (rst)
    (pressPulse && !valueMatch &&
     (state == ST_START || state == ST_GOT1 || state == ST_GOT2))
    |=> (state == ST_ERROR));

  // R2: open is reached only from the second-correct step
  a_r2_open_from_got2: assert property (@(posedge clk) disable iff (rst)
    ((state != ST_OPEN) ##1 (state == ST_OPEN)) |-> ($past(state) == ST_GOT2));

endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CODE0       = 3,
  parameter int unsigned CODE1       = 9,
  parameter int unsigned CODE2       = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VAL_W-1:0] valueIn,
  input  logic             newIn,
  output logic             doorOpen
);

  logic       pressPulse;
  logic       valueMatch;
  ctlStrobe_t ctl;
  lockState_t ctlState;

  lock_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .newIn      (newIn),
    .pressPulse (pressPulse)
  );

  lock_control u_ctl (
    .clk        (clk),
    .rst        (rst),
    .pressPulse (pressPulse),
    .valueMatch (valueMatch),
    .ctl        (ctl),
    .stateOut   (ctlState)
  );

  lock_datapath #(
    .VAL_W       (VAL_W),
    .SYNC_STAGES (SYNC_STAGES),
    .CODE0       (CODE0),
    .CODE1       (CODE1),
    .CODE2       (CODE2)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .valueIn    (valueIn),
    .ctl        (ctl),
    .valueMatch (valueMatch),
    .doorReg    (doorOpen)
  );

  // R3: door register and open step agree every cycle
  a_r3_door_tracks_open: assert property (@(posedge clk) disable iff (rst)
    doorOpen == (ctlState == ST_OPEN));

endmodule

// File: tb/combo_lock_bench.sv
module combo_lock_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] valueIn = 4'd0;
  logic       newIn = 1'b0;
  logic       doorOpen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  combo_lock u_combo_lock (
    .clk      (clk),
    .rst      (rst),
    .valueIn  (valueIn),
    .newIn    (newIn),
    .doorOpen (doorOpen)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s doorOpen actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; newIn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic press(input logic [3:0] v, input int hold);
    @(negedge clk);
    valueIn = v; newIn = 1'b1;
    repeat (hold) @(negedge clk);
    newIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 after reset", doorOpen, 1'b0);
  endtask

  task automatic t_open_and_partial();
    do_reset();
    press(4'd3, 4);
    check("R9 one value", doorOpen, 1'b0);
    press(4'd9, 4);
    check("R9 two values", doorOpen, 1'b0);
    press(4'd5, 4);
    check("R2 full code", doorOpen, 1'b1);
  endtask

  task automatic t_door_timing();
    do_reset();
    press(4'd3, 4);
    press(4'd9, 4);
    @(negedge clk);
    valueIn = 4'd5; newIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R3 low after two edges", doorOpen, 1'b0);
    @(negedge clk);
    check("R3 high after third edge", doorOpen, 1'b1);
    repeat (2) @(negedge clk);
    newIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_open_sticky();
    // continues from open
    press(4'd7, 4);
    check("R6 wrong value in open", doorOpen, 1'b1);
    press(4'd3, 4);
    check("R6 right value in open", doorOpen, 1'b1);
    do_reset();
    check("R1 reset closes door", doorOpen, 1'b0);
  endtask

  task automatic t_wrong_steps();
    do_reset();
    press(4'd0, 4);
    press(4'd3, 4); press(4'd9, 4); press(4'd5, 4);
    check("R4 wrong first value", doorOpen, 1'b0);
    do_reset();
    press(4'd3, 4); press(4'd8, 4);
    press(4'd9, 4); press(4'd5, 4);
    check("R4 wrong second value", doorOpen, 1'b0);
    do_reset();
    press(4'd3, 4); press(4'd9, 4); press(4'd4, 4);
    check("R4 wrong third value", doorOpen, 1'b0);
    press(4'd3, 4); press(4'd9, 4); press(4'd5, 4);
    check("R7 code ignored in error", doorOpen, 1'b0);
    do_reset();
    press(4'd3, 4); press(4'd9, 4); press(4'd5, 4);
    check("R7 code opens after reset", doorOpen, 1'b1);
  endtask

  task automatic t_held_press();
    do_reset();
    press(4'd3, 20);
    press(4'd9, 4);
    press(4'd5, 4);
    check("R5 long press counts once", doorOpen, 1'b1);
  endtask

  task automatic t_reset_priority();
    do_reset();
    press(4'd3, 4);
    press(4'd9, 4);
    @(negedge clk);
    rst = 1'b1; valueIn = 4'd5; newIn = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 press under reset", doorOpen, 1'b0);
    newIn = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 no advance after reset", doorOpen, 1'b0);
    press(4'd5, 4);
    check("R8 state back at start", doorOpen, 1'b0);
    do_reset();
    press(4'd3, 4); press(4'd9, 4); press(4'd5, 4);
    check("R8 code opens from start", doorOpen, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_open_and_partial();
    t_door_timing();
    t_open_sticky();
    t_wrong_steps();
    t_held_press();
    t_reset_priority();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule